// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller

This block sits beside a small CPU core and decides which interrupt, if any, the core should take next. It watches a parameterised set of request lines. A build-time mask sets the type of each line. A latched line records an event in a flag that stays pending until it is served or cleared. A level line is seen only while it is held high. Each line has its own enable bit. A single global enable gates all of them, and the lowest numbered pending line wins.

The controller offers one request and a vector address to the core. The address slot at offset 0 of the table belongs to reset. Source `i` uses the slot at offset `2*(i+1)`, and a select input moves the table base to a configurable boot address. When the core reports that it took the vector, the global enable drops and the served flag is cleared. A return sets the global enable again, but the controller withholds every request until the core retires one ordinary instruction. Software may set the global enable inside a handler to allow nesting. Nested requests use the same fixed priority.

Top module: `prio_irq_ctrl`

## Requirements
- R1: `irq_req` is 1 only if the winning source has its enable bit set in `en_q` and `gie` is 1. With `gie` at 0 or all enables at 0, no request is offered.
- R2: Among pending and enabled sources, the lowest index wins. `irq_vec` equals base + 2*(index+1), and offset 0 is reserved for reset.
- R3: An accepted vector (`irq_taken` while `irq_req`) makes `gie` read 0 from the next cycle. A `reti` pulse, or a `gie_set` pulse, makes `gie` read 1 from the next cycle. A clear in the same cycle beats a set.
- R4: For a latched source, any cycle with its request line at 1 sets its bit in `flags` at the next edge. The bit then stays set whatever the enables are, until it is cleared.
- R5: A latched flag is cleared when its own vector is accepted, or when `flag_clr` carries a 1 in its position. If the event line is high in the same cycle, the flag stays set.
- R6: A level source has no storage. Its `flags` bit always reads 0, and a pulse that ends before the source is enabled produces no request.
- R7: After a `reti`, `irq_req` stays 0 until a cycle with `retire` at 1 and `reti` at 0 has passed.
- R8: A `gie_clr` pulse forces `irq_req` to 0 in that same cycle.
- R9: With `vec_sel` at 0 the table base is 0. With `vec_sel` at 1 the base is `BOOT_BASE` (default 0xC00).
- R10: Reset (synchronous, active low) clears `en_q`, `flags`, `gie` and the post-return hold. The enable register loads `en_wdata` on a cycle with `en_we` at 1.
- R11: A `gie_set` issued inside a handler lets a new pending request through, chosen by the same fixed priority.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_req | input | N_SRC | Request lines; event pulses for latched sources, held conditions for level sources |
| en_we | input | 1 | Write strobe for the enable register |
| en_wdata | input | N_SRC | New enable register value |
| flag_clr | input | N_SRC | Write-one-to-clear mask for the latched flags |
| gie_set | input | 1 | Set the global enable |
| gie_clr | input | 1 | Clear the global enable; effective in the same cycle |
| vec_sel | input | 1 | Table base select: 0 = address 0, 1 = boot base |
| irq_taken | input | 1 | Core accepts the offered vector |
| reti | input | 1 | Core executes a return from interrupt |
| retire | input | 1 | Core retires an instruction |
| irq_req | output | 1 | A vector is offered |
| irq_id | output | ID_W | Index of the winning source |
| irq_vec | output | ADDR_W | Vector address of the winning source |
| gie | output | 1 | Global enable state |
| en_q | output | N_SRC | Enable register contents |
| flags | output | N_SRC | Latched flag contents (0 for level sources) |

## Verification
The decision path from the stored state to `irq_req`, `irq_id` and `irq_vec` is combinational. A level line, a `gie_clr` or a change of `vec_sel` therefore shows on the outputs in the same cycle. Flags, enables, `gie` and the post-return hold are registers, so their effects become visible one edge after the stimulus. The bench drives every input just after a falling edge and samples a quarter period later. A same-cycle result is read before the next rising edge, and a registered result is read after exactly one rising edge has passed. For the "stays pending" and "still held" cases, extra idle edges are inserted before sampling.

// File: rtl/irq_ctrl_pkg.sv
// Package: shared helpers for the interrupt controller.
// Assumes slot 0 of the vector table belongs to reset and each source
// occupies two address units.
package irq_ctrl_pkg;

    localparam int unsigned SLOT_UNITS = 2;

    // Offset of a source's slot from the table base (reset owns offset 0).
    function automatic int unsigned slot_offset(input int unsigned idx);
        return (idx + 1) * SLOT_UNITS;
    endfunction

endpackage

// File: rtl/irq_src_bank.sv
// Module: irq_src_bank
// Holds the per-source enable register and, for latched sources, the
// pending flags. Produces the pending-and-enabled vector for arbitration.
// Assumes take_clr is one-hot or zero and only marks a source being served.
module irq_src_bank #(
    parameter int unsigned N_SRC      = 8,
    parameter logic [N_SRC-1:0] LEVEL_MASK = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] src_req,
    input  logic             en_we,
    input  logic [N_SRC-1:0] en_wdata,
    input  logic [N_SRC-1:0] flag_clr,
    input  logic [N_SRC-1:0] take_clr,
    output logic [N_SRC-1:0] en_q,
    output logic [N_SRC-1:0] flag_q,
    output logic [N_SRC-1:0] pend
);

    // Enable register: reset to all off, loaded on a write strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)
            en_q <= '0;
        else if (en_we)
            en_q <= en_wdata;
    end

    for (genvar i = 0; i < N_SRC; i++) begin : g_src
        if (LEVEL_MASK[i]) begin : g_level
            // Level source: no storage, request only while the line is high.
            assign flag_q[i] = 1'b0;
            assign pend[i]   = src_req[i] & en_q[i];

            // R6: a level source is only served while its line is asserted
            assert_level_live_R6: assert property (@(posedge clk) disable iff (!rst_n)
                take_clr[i] |-> (src_req[i] && en_q[i]));
            // R6: software clear has nothing to act on for a level source
            assert_level_noflag_R6: assert property (@(posedge clk) disable iff (!rst_n)
                flag_clr[i] |=> !flag_q[i]);
        end else begin : g_latch
            logic flag_r;

            // Latched flag: event sets, service or write-one clears, event wins.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    flag_r <= 1'b0;
                else if (src_req[i])
                    flag_r <= 1'b1;
                else if (flag_clr[i] || take_clr[i])
                    flag_r <= 1'b0;
            end

            assign flag_q[i] = flag_r;
            assign pend[i]   = flag_r & en_q[i];

            assert_flag_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
                (flag_q[i] && !flag_clr[i] && !take_clr[i]) |=> flag_q[i]);
            assert_event_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
                src_req[i] |=> flag_q[i]);
            assert_take_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
                (take_clr[i] && !src_req[i]) |=> !flag_q[i]);
        end
    end

endmodule

// File: rtl/irq_prio_pick.sv
// Module: irq_prio_pick
// Fixed-priority encoder: returns the lowest set index of the pending
// vector and whether any bit is set. Purely combinational.
module irq_prio_pick #(
    parameter int unsigned N_SRC = 8,
    parameter int unsigned ID_W  = 3
) (
    input  logic [N_SRC-1:0] pend,
    output logic             any,
    output logic [ID_W-1:0]  id
);

    // Scan from the top down so the lowest set index is written last.
    always_comb begin
        any = 1'b0;
        id  = '0;
        for (int i = N_SRC - 1; i >= 0; i--) begin
            if (pend[i]) begin
                any = 1'b1;
                id  = ID_W'(i);
            end
        end
    end

endmodule

// File: rtl/irq_gate_ctrl.sv
// Module: irq_gate_ctrl
// Owns the global enable and the post-return hold that keeps requests
// back until one ordinary instruction has retired. Clears beat sets.
module irq_gate_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic gie_set,
    input  logic gie_clr,
    input  logic take,
    input  logic reti,
    input  logic retire,
    output logic gie_q,
    output logic hold_q
);

    // Global enable: cleared on entry or by software, set on return or by software.
    always_ff @(posedge clk) begin
        if (!rst_n)
            gie_q <= 1'b0;
        else if (take || gie_clr)
            gie_q <= 1'b0;
        else if (reti || gie_set)
            gie_q <= 1'b1;
    end

    // Post-return hold: armed by a return, released by a later retire.
    always_ff @(posedge clk) begin
        if (!rst_n)
            hold_q <= 1'b0;
        else if (reti)
            hold_q <= 1'b1;
        else if (retire)
            hold_q <= 1'b0;
    end

    assert_take_clears_gie_R3: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> !gie_q);
    assert_reti_sets_gie_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (reti && !take && !gie_clr) |=> gie_q);
    assert_reti_arms_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        reti |=> hold_q);

endmodule

// File: rtl/prio_irq_ctrl.sv
// Module: prio_irq_ctrl (top)
// Fixed-priority vectored interrupt controller. Combines the source bank,
// the priority encoder and the global-enable gate, and forms the vector
// address from the selected table base. Assumes the core raises irq_taken
// only while irq_req is 1.
module prio_irq_ctrl
    import irq_ctrl_pkg::*;
#(
    parameter int unsigned N_SRC      = 8,
    parameter logic [N_SRC-1:0] LEVEL_MASK = 8'hF0,
    parameter int unsigned ADDR_W     = 12,
    parameter int unsigned BOOT_BASE  = 'hC00,
    localparam int unsigned ID_W      = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_SRC-1:0]  src_req,
    input  logic              en_we,
    input  logic [N_SRC-1:0]  en_wdata,
    input  logic [N_SRC-1:0]  flag_clr,
    input  logic              gie_set,
    input  logic              gie_clr,
    input  logic              vec_sel,
    input  logic              irq_taken,
    input  logic              reti,
    input  logic              retire,
    output logic              irq_req,
    output logic [ID_W-1:0]   irq_id,
    output logic [ADDR_W-1:0] irq_vec,
    output logic              gie,
    output logic [N_SRC-1:0]  en_q,
    output logic [N_SRC-1:0]  flags
);

    logic [N_SRC-1:0]  pend;
    logic [N_SRC-1:0]  take_clr;
    logic              any_pend;
    logic [ID_W-1:0]   win_id;
    logic              hold_q;
    logic              take;
    logic [ADDR_W-1:0] base;

    irq_src_bank #(.N_SRC(N_SRC), .LEVEL_MASK(LEVEL_MASK)) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .src_req  (src_req),
        .en_we    (en_we),
        .en_wdata (en_wdata),
        .flag_clr (flag_clr),
        .take_clr (take_clr),
        .en_q     (en_q),
        .flag_q   (flags),
        .pend     (pend)
    );

    irq_prio_pick #(.N_SRC(N_SRC), .ID_W(ID_W)) u_pick (
        .pend (pend),
        .any  (any_pend),
        .id   (win_id)
    );

    irq_gate_ctrl u_gate (
        .clk     (clk),
        .rst_n   (rst_n),
        .gie_set (gie_set),
        .gie_clr (gie_clr),
        .take    (take),
        .reti    (reti),
        .retire  (retire),
        .gie_q   (gie),
        .hold_q  (hold_q)
    );

    // Offer a vector only when enabled globally, not held, and not being masked now.
    always_comb begin
        irq_req = any_pend & gie & ~gie_clr & ~hold_q;
        irq_id  = win_id;
        take    = irq_taken & irq_req;
    end

    // One-hot service strobe for the flag of the accepted source.
    always_comb begin
        take_clr = '0;
        if (take)
            take_clr[win_id] = 1'b1;
    end

    // Vector address: selected base plus the source's slot offset.
    always_comb begin
        base    = vec_sel ? ADDR_W'(BOOT_BASE) : '0;
        irq_vec = base + ADDR_W'(slot_offset(int'(win_id)));
    end

    assert_req_needs_enable_R1: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> (gie && en_q[irq_id]));
    assert_lowest_wins_R2: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> ((pend & ((N_SRC'(1) << irq_id) - N_SRC'(1))) == '0));
    assert_clr_masks_R8: assert property (@(posedge clk) disable iff (!rst_n)
        gie_clr |-> !irq_req);
    assert_no_req_after_reti_R7: assert property (@(posedge clk) disable iff (!rst_n)
        reti |=> !irq_req);
    assert_taken_offered_R3: assert property (@(posedge clk) disable iff (!rst_n)
        irq_taken |-> irq_req);

endmodule

// File: tb/prio_irq_ctrl_tb.sv
// Bench for prio_irq_ctrl: a table walk of arbitration cases on the level
// sources, then directed tests of reset, flags, entry, return and masking.
module prio_irq_ctrl_tb;

    localparam int unsigned N      = 8;
    localparam int unsigned ADDR_W = 12;
    localparam int unsigned NVEC   = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [N-1:0]      src_req = '0;
    logic              en_we = 1'b0;
    logic [N-1:0]      en_wdata = '0;
    logic [N-1:0]      flag_clr = '0;
    logic              gie_set = 1'b0;
    logic              gie_clr = 1'b0;
    logic              vec_sel = 1'b0;
    logic              irq_taken = 1'b0;
    logic              reti = 1'b0;
    logic              retire = 1'b0;
    logic              irq_req;
    logic [2:0]        irq_id;
    logic [ADDR_W-1:0] irq_vec;
    logic              gie;
    logic [N-1:0]      en_q;
    logic [N-1:0]      flags;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    prio_irq_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .src_req(src_req), .en_we(en_we),
        .en_wdata(en_wdata), .flag_clr(flag_clr), .gie_set(gie_set),
        .gie_clr(gie_clr), .vec_sel(vec_sel), .irq_taken(irq_taken),
        .reti(reti), .retire(retire), .irq_req(irq_req), .irq_id(irq_id),
        .irq_vec(irq_vec), .gie(gie), .en_q(en_q), .flags(flags)
    );

    // Entry: {vec_sel, enables, level lines, expected req, expected vector}
    localparam logic [29:0] TBL [NVEC] = '{
        {1'b0, 8'hFF, 8'hF0, 1'b1, 12'h00A},   // R2: source 4 wins
        {1'b0, 8'hFF, 8'hC0, 1'b1, 12'h00E},   // R2: source 6 wins
        {1'b0, 8'h7F, 8'h80, 1'b0, 12'h000},   // R1: line high but disabled
        {1'b0, 8'hE0, 8'h90, 1'b1, 12'h010},   // R1/R2: 4 disabled, 7 wins
        {1'b1, 8'hFF, 8'hA0, 1'b1, 12'hC0C},   // R9: boot base, source 5
        {1'b1, 8'hFF, 8'h80, 1'b1, 12'hC10},   // R9: boot base, source 7
        {1'b0, 8'h00, 8'hF0, 1'b0, 12'h000},   // R1: all enables off
        {1'b0, 8'h20, 8'h20, 1'b1, 12'h00C}    // R2: single source 5
    };

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic cyc();
        @(negedge clk);
    endtask

    task automatic settle();
        #5;
    endtask

    task automatic write_en(input logic [N-1:0] v);
        en_we = 1'b1; en_wdata = v;
        cyc();
        en_we = 1'b0;
    endtask

    initial begin
        // Reset state (R10)
        repeat (3) cyc();
        settle();
        chk(irq_req, 0, "R10 reset irq_req");
        chk(gie, 0, "R10 reset gie");
        chk(flags, 0, "R10 reset flags");
        chk(en_q, 0, "R10 reset en_q");
        rst_n = 1'b1;
        cyc();

        // Table walk over level sources
        gie_set = 1'b1;
        cyc();
        gie_set = 1'b0;
        for (int k = 0; k < NVEC; k++) begin
            vec_sel = TBL[k][29];
            src_req = TBL[k][20:13];
            write_en(TBL[k][28:21]);
            settle();
            chk(en_q, TBL[k][28:21], "R10 enable write");
            chk(irq_req, TBL[k][12], "R1/R2 table req");
            if (TBL[k][12])
                chk(irq_vec, TBL[k][11:0], "R2/R9 table vector");
        end
        src_req = '0; vec_sel = 1'b0;

        // R4: latched flag stays pending while disabled
        gie_clr = 1'b1;
        cyc();
        gie_clr = 1'b0;
        write_en('0);
        src_req = 8'h04;
        cyc();
        src_req = '0;
        settle();
        chk(flags[2], 1, "R4 flag set by event");
        chk(irq_req, 0, "R1 no req while disabled");
        repeat (3) cyc();
        settle();
        chk(flags[2], 1, "R4 flag still pending");

        // R1: enable alone is not enough
        write_en(8'h04);
        settle();
        chk(irq_req, 0, "R1 gie off blocks");
        gie_set = 1'b1;
        cyc();
        gie_set = 1'b0;
        settle();
        chk(irq_req, 1, "R1 both enables give req");
        chk(irq_vec, 12'h006, "R2 vector of source 2");

        // R3/R5: accepting clears gie and the served flag
        irq_taken = 1'b1;
        cyc();
        irq_taken = 1'b0;
        settle();
        chk(flags[2], 0, "R5 hardware clear on take");
        chk(gie, 0, "R3 gie cleared on entry");
        chk(irq_req, 0, "R3 no req after entry");

        // R11: nesting inside the handler
        write_en(8'h0F);
        src_req = 8'h03;
        cyc();
        src_req = '0;
        settle();
        chk(irq_req, 0, "R11 no req before re-enable");
        gie_set = 1'b1;
        cyc();
        gie_set = 1'b0;
        settle();
        chk(irq_req, 1, "R11 nested req");
        chk(irq_id, 0, "R11 priority in nesting");
        chk(irq_vec, 12'h002, "R11 nested vector");
        irq_taken = 1'b1;
        cyc();
        irq_taken = 1'b0;
        settle();
        chk(flags, 8'h02, "R5 only served flag cleared");

        // R7: return holds requests until one instruction retires
        reti = 1'b1;
        cyc();
        reti = 1'b0;
        settle();
        chk(gie, 1, "R3 return sets gie");
        chk(irq_req, 0, "R7 held right after return");
        cyc();
        settle();
        chk(irq_req, 0, "R7 still held without retire");
        retire = 1'b1;
        cyc();
        retire = 1'b0;
        settle();
        chk(irq_req, 1, "R7 released after retire");
        chk(irq_vec, 12'h004, "R7 vector of source 1");

        // R8: same-cycle clear masks the request
        gie_clr = 1'b1;
        #1;
        chk(irq_req, 0, "R8 clear masks same cycle");
        cyc();
        gie_clr = 1'b0;
        settle();
        chk(gie, 0, "R3 gie cleared by software");

        // R5: software write-one clear, and event beating clear
        flag_clr = 8'h02;
        cyc();
        flag_clr = '0;
        settle();
        chk(flags[1], 0, "R5 software clear");
        src_req = 8'h02; flag_clr = 8'h02;
        cyc();
        src_req = '0; flag_clr = '0;
        settle();
        chk(flags[1], 1, "R5 event wins over clear");
        flag_clr = 8'h02;
        cyc();
        flag_clr = '0;

        // R6: level pulse before enabling is lost
        write_en('0);
        src_req = 8'h20;
        cyc();
        src_req = '0;
        write_en(8'h20);
        gie_set = 1'b1;
        cyc();
        gie_set = 1'b0;
        settle();
        chk(irq_req, 0, "R6 level pulse lost");
        chk(flags[5], 0, "R6 level has no flag");
        src_req = 8'h20;
        #1;
        chk(irq_req, 1, "R6 level seen while high");
        chk(irq_vec, 12'h00C, "R6 level vector");
        cyc();
        src_req = '0;

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        #(200000 * 20);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule